// File: doc/BRIEF.md
# Smart Card Power-Up and Power-Down Sequencer

This block steps a smart card contact set through a timed power-up and power-down. The host starts a session by pulling an active-low command line low while a debounced card is present and the power-on reset pulse is inactive. The sequencer then turns on the supply converter, raises the card supply, releases the data lines, starts the card clock and finally hands the card reset over to the host. Releasing the command runs the same steps in reverse.

Every step lands on a multiple of half a time unit. One unit T is 64 periods of the internal oscillator clock, so a half unit is `HALF_TICKS` (default 32) cycles. A fault flag (overcurrent, overheating, supply drop, converter out of range) or a card extraction during a session starts an emergency power-down at once, and the status output goes low. The status output is modelled as a level (low = pull low). It mirrors card presence outside a session.

States: `ST_IDLE` (inactive), `ST_RAMP_UP` (timed power-up), `ST_LIVE` (session), `ST_RAMP_DOWN` (timed power-down), `ST_HOLD_OFF` (wait for command release). Transitions:
- IDLE to RAMP_UP on a start request.
- RAMP_UP to LIVE at step 14.
- RAMP_UP or LIVE to RAMP_DOWN on an abort (command high, any fault, or the raw presence lost).
- RAMP_DOWN to IDLE or HOLD_OFF at step 10, depending on the command.
- HOLD_OFF to IDLE once the command is high.

Top module: `card_seq_top`

## Requirements
- R1: During and right after reset, the outputs are as follows: every enable is low, `card_rst` is low, `osc_fast` is low, and `status_n` is low (no debounced card yet).
- R2: The raw card presence is `card_det_n` low OR `card_det` high. `status_n` rises `DEB_CYCLES` cycles after the raw presence becomes true. It drops on the cycle after the raw presence is lost.
- R3: A session starts only when all three hold: `cmd_n` is low, the debounced presence is true, and `por_active` is low. With no card, or while `por_active` is high, `cmd_n` low changes no output.
- R4: Let S be the cycle after the clock edge that sees the start request. `conv_en` and `osc_fast` rise at S, `vcc_en` rises at S+3·HALF_TICKS, and `data_en` rises at S+8·HALF_TICKS.
- R5: If `host_rst` was low at the start, `clk_en` rises together with `data_en`. If it was high, `clk_en` rises in the first cycle at or after S+8·HALF_TICKS in which `host_rst` is low.
- R6: `card_rst` stays low until S+14·HALF_TICKS. From then on it equals `host_rst` in the same cycle.
- R7: Let D be the cycle after the clock edge that sees the abort. `card_rst` falls at D, `clk_en` at D+HALF_TICKS, `data_en` at D+2·HALF_TICKS, `vcc_en` at D+3·HALF_TICKS and `conv_en` at D+10·HALF_TICKS. `osc_fast` falls one cycle after `conv_en`. An output that was never raised stays low.
- R8: In a session, a fault flag or the loss of the raw presence drives `status_n` low at D and runs the R7 power-down.
- R9: After an emergency, `status_n` stays low until the power-down has finished and `cmd_n` is high. It then shows the debounced presence again.
- R10: If `cmd_n` is still low when a power-down ends, no new session starts until `cmd_n` has been high.
- R11: Outside a session the fault flags change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_active | input | 1 | Power-on reset pulse in progress; blocks a start |
| cmd_n | input | 1 | Host session command, active low |
| host_rst | input | 1 | Host card-reset request |
| card_det_n | input | 1 | Presence switch, active low |
| card_det | input | 1 | Presence switch, active high |
| flt_overcur | input | 1 | Card supply overcurrent |
| flt_overtemp | input | 1 | Overheating |
| flt_supply | input | 1 | Logic supply drop |
| flt_conv | input | 1 | Converter out of range |
| conv_en | output | 1 | Supply converter enable |
| vcc_en | output | 1 | Card supply up |
| data_en | output | 1 | Data lines released (low when 0) |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset contact |
| status_n | output | 1 | Status/interrupt, low = pull low |
| osc_fast | output | 1 | Oscillator speed select, high = fast |

## Verification
The outputs that come from registers change in the cycle after the edge that sees the stimulus, plus a whole number of half units. `card_rst` and the host-driven clock start follow `host_rst` combinationally, so they change in the same cycle. The bench counts clock edges. For every stimulus it queues each expected output change with its exact cycle. It then samples the outputs one nanosecond after each falling edge, well away from the rising edge. Any change that is out of place, or that nothing predicted, is reported.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RAMP_UP   = 3'd1,
        ST_LIVE      = 3'd2,
        ST_RAMP_DOWN = 3'd3,
        ST_HOLD_OFF  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/card_seq_timebase.sv
// Half-unit step counter: step advances once every HALF_TICKS cycles and saturates.
module card_seq_timebase #(
    parameter int HALF_TICKS = 32,
    parameter int STEP_MAX   = 15,
    localparam int PW = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1,
    localparam int SW = $clog2(STEP_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [SW-1:0] step
);
    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            step  <= '0;
        end else if (restart) begin
            pre_q <= '0;
            step  <= '0;
        end else if (pre_q == PW'(HALF_TICKS - 1)) begin
            pre_q <= '0;
            if (step != SW'(STEP_MAX))
                step <= step + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/card_seq_debounce.sv
// Presence debounce: the raw loss of presence is immediate; a new presence is confirmed after DEB_CYCLES.
module card_seq_debounce #(
    parameter int DEB_CYCLES = 2048,
    localparam int CW = $clog2(DEB_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_det_n,
    input  logic card_det,
    output logic present_raw,
    output logic present_db
);
    logic [CW-1:0] cnt_q;

    assign present_raw = !card_det_n || card_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            present_db <= 1'b0;
        end else if (!present_raw) begin
            cnt_q      <= '0;
            present_db <= 1'b0;
        end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            present_db <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
    import card_seq_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    input  logic              present_raw,
    input  logic              present_db,
    input  logic              por_active,
    input  logic              cmd_n,
    input  logic              host_rst,
    input  logic              fault_any,
    output logic              restart,
    output logic              conv_en,
    output logic              vcc_en,
    output logic              data_en,
    output logic              clk_en,
    output logic              card_rst,
    output logic              status_n,
    output logic              osc_fast,
    output logic              in_session
);
    // step points, in half units
    localparam logic [STEP_W-1:0] UP_VCC  = STEP_W'(3);
    localparam logic [STEP_W-1:0] UP_DATA = STEP_W'(8);
    localparam logic [STEP_W-1:0] UP_RST  = STEP_W'(14);
    localparam logic [STEP_W-1:0] DN_CLK  = STEP_W'(1);
    localparam logic [STEP_W-1:0] DN_DATA = STEP_W'(2);
    localparam logic [STEP_W-1:0] DN_VCC  = STEP_W'(3);
    localparam logic [STEP_W-1:0] DN_CONV = STEP_W'(10);

    seq_state_t st, nxt;
    logic rst_hi_q, clk_run_q, vcc_up_q, data_up_q, fault_q;
    logic abort, go_now;

    assign abort  = cmd_n || fault_any || !present_raw;
    assign go_now = (st == ST_RAMP_UP) && (step >= UP_DATA) && (!rst_hi_q || !host_rst);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:      if (!cmd_n && present_db && !por_active) nxt = ST_RAMP_UP;
            ST_RAMP_UP:   if (abort) nxt = ST_RAMP_DOWN;
                          else if (step >= UP_RST) nxt = ST_LIVE;
            ST_LIVE:      if (abort) nxt = ST_RAMP_DOWN;
            ST_RAMP_DOWN: if (step >= DN_CONV) nxt = cmd_n ? ST_IDLE : ST_HOLD_OFF;
            ST_HOLD_OFF:  if (cmd_n) nxt = ST_IDLE;
        endcase
    end

    assign restart = (nxt != st) && (nxt == ST_RAMP_UP || nxt == ST_RAMP_DOWN);

    // state register and session bookkeeping flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            rst_hi_q  <= 1'b0;
            clk_run_q <= 1'b0;
            vcc_up_q  <= 1'b0;
            data_up_q <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && nxt == ST_RAMP_UP)
                rst_hi_q <= host_rst;
            if (go_now || st == ST_LIVE)
                clk_run_q <= 1'b1;
            else if (st == ST_IDLE)
                clk_run_q <= 1'b0;
            if ((st == ST_RAMP_UP && step >= UP_VCC) || st == ST_LIVE)
                vcc_up_q <= 1'b1;
            else if (st == ST_IDLE)
                vcc_up_q <= 1'b0;
            if ((st == ST_RAMP_UP && step >= UP_DATA) || st == ST_LIVE)
                data_up_q <= 1'b1;
            else if (st == ST_IDLE)
                data_up_q <= 1'b0;
            if (in_session && (fault_any || !present_raw))
                fault_q <= 1'b1;
            else if (nxt == ST_IDLE)
                fault_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        in_session = (st == ST_RAMP_UP) || (st == ST_LIVE);
        osc_fast   = in_session || (st == ST_RAMP_DOWN);
        conv_en    = in_session || (st == ST_RAMP_DOWN && step < DN_CONV);
        vcc_en     = (st == ST_RAMP_UP && step >= UP_VCC) || (st == ST_LIVE)
                   || (st == ST_RAMP_DOWN && vcc_up_q && step < DN_VCC);
        data_en    = (st == ST_RAMP_UP && step >= UP_DATA) || (st == ST_LIVE)
                   || (st == ST_RAMP_DOWN && data_up_q && step < DN_DATA);
        clk_en     = (st == ST_RAMP_UP && (clk_run_q || go_now)) || (st == ST_LIVE)
                   || (st == ST_RAMP_DOWN && clk_run_q && step < DN_CLK);
        card_rst   = host_rst && ((st == ST_RAMP_UP && step >= UP_RST) || st == ST_LIVE);
        status_n   = present_db && !fault_q;
    end
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top #(
    parameter int HALF_TICKS = 32,
    parameter int DEB_CYCLES = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_active,
    input  logic cmd_n,
    input  logic host_rst,
    input  logic card_det_n,
    input  logic card_det,
    input  logic flt_overcur,
    input  logic flt_overtemp,
    input  logic flt_supply,
    input  logic flt_conv,
    output logic conv_en,
    output logic vcc_en,
    output logic data_en,
    output logic clk_en,
    output logic card_rst,
    output logic status_n,
    output logic osc_fast
);
    localparam int STEP_MAX = 15;
    localparam int STEP_W   = $clog2(STEP_MAX + 1);

    logic [STEP_W-1:0] step;
    logic restart, present_raw, present_db, fault_any, in_session;

    assign fault_any = flt_overcur || flt_overtemp || flt_supply || flt_conv;

    card_seq_timebase #(.HALF_TICKS(HALF_TICKS), .STEP_MAX(STEP_MAX)) u_tb (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step)
    );

    card_seq_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .card_det_n(card_det_n), .card_det(card_det),
        .present_raw(present_raw), .present_db(present_db)
    );

    card_seq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step(step), .present_raw(present_raw),
        .present_db(present_db), .por_active(por_active), .cmd_n(cmd_n),
        .host_rst(host_rst), .fault_any(fault_any), .restart(restart),
        .conv_en(conv_en), .vcc_en(vcc_en), .data_en(data_en), .clk_en(clk_en),
        .card_rst(card_rst), .status_n(status_n), .osc_fast(osc_fast),
        .in_session(in_session)
    );
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic por_active,
    input logic cmd_n,
    input logic fault_any,
    input logic in_session,
    input logic conv_en,
    input logic vcc_en,
    input logic data_en,
    input logic clk_en,
    input logic card_rst,
    input logic status_n,
    input logic osc_fast
);
    AST_VCC_UNDER_CONV: assert property (@(posedge clk) disable iff (!rst_n) vcc_en |-> conv_en); // R4
    AST_DATA_UNDER_VCC: assert property (@(posedge clk) disable iff (!rst_n) data_en |-> vcc_en); // R4
    AST_CLK_UNDER_DATA: assert property (@(posedge clk) disable iff (!rst_n) clk_en |-> data_en); // R5
    AST_RST_UNDER_DATA: assert property (@(posedge clk) disable iff (!rst_n) card_rst |-> data_en); // R6
    AST_START_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_en) |-> $past(!por_active && !cmd_n)); // R3
    AST_FAULT_DROPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_session && fault_any) |=> !status_n); // R8
    AST_FAST_WHILE_POWERED: assert property (@(posedge clk) disable iff (!rst_n) conv_en |-> osc_fast); // R7
endmodule

bind card_seq_top card_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .cmd_n(cmd_n),
    .fault_any(fault_any), .in_session(in_session), .conv_en(conv_en),
    .vcc_en(vcc_en), .data_en(data_en), .clk_en(clk_en), .card_rst(card_rst),
    .status_n(status_n), .osc_fast(osc_fast)
);

// File: tb/card_seq_top_bench.sv
`timescale 1ns/1ps
module card_seq_top_bench;
    localparam int H   = 4;
    localparam int DEB = 40;

    logic clk = 1'b0, rst_n = 1'b0, por_active = 1'b0, cmd_n = 1'b1, host_rst = 1'b0;
    logic card_det_n = 1'b1, card_det = 1'b0;
    logic f_oc = 1'b0, f_ot = 1'b0, f_sd = 1'b0, f_cv = 1'b0;
    logic conv_en, vcc_en, data_en, clk_en, card_rst, status_n, osc_fast;

    card_seq_top #(.HALF_TICKS(H), .DEB_CYCLES(DEB)) u_card_seq_top (
        .clk(clk), .rst_n(rst_n), .por_active(por_active), .cmd_n(cmd_n),
        .host_rst(host_rst), .card_det_n(card_det_n), .card_det(card_det),
        .flt_overcur(f_oc), .flt_overtemp(f_ot), .flt_supply(f_sd), .flt_conv(f_cv),
        .conv_en(conv_en), .vcc_en(vcc_en), .data_en(data_en), .clk_en(clk_en),
        .card_rst(card_rst), .status_n(status_n), .osc_fast(osc_fast)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    bit_i;
        logic  val;
        string tag;
    } ev_t;
    ev_t q[$];

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [6:0] obs, prev;
    assign obs = {osc_fast, status_n, card_rst, clk_en, data_en, vcc_en, conv_en};
    string nm [7] = '{"conv_en", "vcc_en", "data_en", "clk_en", "card_rst", "status_n", "osc_fast"};

    task automatic expect_ev(int at, int b, logic v, string tag);
        ev_t e;
        e.at = at; e.bit_i = b; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: every output change must match the head of the queue
    initial begin
        ev_t e;
        prev = '0;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) prev = obs;
            else begin
                for (int b = 0; b < 7; b++) begin
                    if (obs[b] !== prev[b]) begin
                        checks++;
                        if (q.size() == 0) begin
                            fails++;
                            $display("FAIL quiet window (R3 R10 R11): %s=%0b at cycle %0d, expected no change",
                                     nm[b], obs[b], cyc);
                        end else begin
                            e = q.pop_front();
                            if (e.bit_i != b || e.at != cyc || e.val !== obs[b]) begin
                                fails++;
                                $display("FAIL %s: %s=%0b at cycle %0d, expected %s=%0b at cycle %0d",
                                         e.tag, nm[b], obs[b], cyc, nm[e.bit_i], e.val, e.at);
                            end
                        end
                    end
                end
                prev = obs;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog (all requirements): cycle %0d, expected end before 20000", cyc);
        finish_run();
    end

    initial begin
        int c, s, d;
        repeat (3) @(negedge clk);
        check(obs == 7'b0, "R1 reset outputs", obs, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(obs == 7'b0, "R1 after reset", obs, 0);

        // R3: no card, command ignored
        cmd_n = 1'b0;
        repeat (30) @(negedge clk);
        check(conv_en == 1'b0, "R3 no card", conv_en, 0);
        cmd_n = 1'b1;
        @(negedge clk);

        // R2: insertion on the active-low input
        c = cyc; card_det_n = 1'b0;
        expect_ev(c + DEB, 5, 1'b1, "R2 debounce low input");
        wait_until(c + DEB + 3);

        // R3: power-on reset pulse blocks a start
        por_active = 1'b1; cmd_n = 1'b0;
        repeat (30) @(negedge clk);
        check(conv_en == 1'b0, "R3 por blocks", conv_en, 0);
        cmd_n = 1'b1; por_active = 1'b0;
        @(negedge clk);

        // R4/R5: activation with host reset low
        c = cyc; cmd_n = 1'b0; s = c + 1;
        expect_ev(s, 0, 1'b1, "R4 conv");
        expect_ev(s, 6, 1'b1, "R4 osc fast");
        expect_ev(s + 3*H, 1, 1'b1, "R4 vcc");
        expect_ev(s + 8*H, 2, 1'b1, "R4 data");
        expect_ev(s + 8*H, 3, 1'b1, "R5 clk at data");
        wait_until(s + 14*H + 2);
        check(card_rst == 1'b0, "R6 low while host low", card_rst, 0);
        host_rst = 1'b1; expect_ev(cyc, 4, 1'b1, "R6 follow high");
        repeat (3) @(negedge clk);
        host_rst = 1'b0; expect_ev(cyc, 4, 1'b0, "R6 follow low");
        repeat (3) @(negedge clk);
        host_rst = 1'b1; expect_ev(cyc, 4, 1'b1, "R6 follow high");
        repeat (3) @(negedge clk);

        // R7: normal deactivation
        c = cyc; cmd_n = 1'b1; d = c + 1;
        expect_ev(d, 4, 1'b0, "R7 rst");
        expect_ev(d + H, 3, 1'b0, "R7 clk");
        expect_ev(d + 2*H, 2, 1'b0, "R7 data");
        expect_ev(d + 3*H, 1, 1'b0, "R7 vcc");
        expect_ev(d + 10*H, 0, 1'b0, "R7 conv");
        expect_ev(d + 10*H + 1, 6, 1'b0, "R7 osc slow");
        wait_until(d + 10*H + 4);

        // R5/R6: host reset high at start, clock waits for it to drop
        @(negedge clk);
        c = cyc; cmd_n = 1'b0; s = c + 1;
        expect_ev(s, 0, 1'b1, "R4 conv");
        expect_ev(s, 6, 1'b1, "R4 osc fast");
        expect_ev(s + 3*H, 1, 1'b1, "R4 vcc");
        expect_ev(s + 8*H, 2, 1'b1, "R4 data");
        wait_until(s + 10*H);
        check(clk_en == 1'b0, "R5 clk held", clk_en, 0);
        host_rst = 1'b0; expect_ev(cyc, 3, 1'b1, "R5 clk on host drop");
        wait_until(s + 14*H + 2);
        check(card_rst == 1'b0, "R6 follows low", card_rst, 0);
        host_rst = 1'b1; expect_ev(cyc, 4, 1'b1, "R6 follow high");
        repeat (3) @(negedge clk);

        // R8: fault in session
        c = cyc; f_ot = 1'b1; d = c + 1;
        expect_ev(d, 4, 1'b0, "R8 rst");
        expect_ev(d, 5, 1'b0, "R8 status low");
        expect_ev(d + H, 3, 1'b0, "R8 clk");
        expect_ev(d + 2*H, 2, 1'b0, "R8 data");
        expect_ev(d + 3*H, 1, 1'b0, "R8 vcc");
        expect_ev(d + 10*H, 0, 1'b0, "R8 conv");
        expect_ev(d + 10*H + 1, 6, 1'b0, "R8 osc slow");
        wait_until(d + 2);
        f_ot = 1'b0;
        wait_until(d + 10*H + 3);

        // R10/R9: command still low, nothing restarts, status stays low
        repeat (30) @(negedge clk);
        check(conv_en == 1'b0, "R10 no restart", conv_en, 0);
        check(status_n == 1'b0, "R9 status held", status_n, 0);
        c = cyc; cmd_n = 1'b1;
        expect_ev(c + 1, 5, 1'b1, "R9 status back");
        repeat (4) @(negedge clk);
        host_rst = 1'b0;

        // R8: extraction during power-up
        c = cyc; cmd_n = 1'b0; s = c + 1;
        expect_ev(s, 0, 1'b1, "R4 conv");
        expect_ev(s, 6, 1'b1, "R4 osc fast");
        wait_until(s + H);
        c = cyc; card_det_n = 1'b1; d = c + 1;
        expect_ev(d, 5, 1'b0, "R8 extraction status");
        expect_ev(d + 10*H, 0, 1'b0, "R8 conv");
        expect_ev(d + 10*H + 1, 6, 1'b0, "R8 osc slow");
        wait_until(d + 10*H + 3);
        check(vcc_en == 1'b0, "R7 vcc never raised", vcc_en, 0);
        cmd_n = 1'b1;
        repeat (4) @(negedge clk);
        check(status_n == 1'b0, "R9 no card after release", status_n, 0);

        // R2: insertion on the active-high input, then R11 faults outside a session
        c = cyc; card_det = 1'b1;
        expect_ev(c + DEB, 5, 1'b1, "R2 debounce high input");
        wait_until(c + DEB + 2);
        f_oc = 1'b1; f_sd = 1'b1; f_cv = 1'b1; f_ot = 1'b1;
        repeat (20) @(negedge clk);
        check(obs == 7'b0100000, "R11 faults idle", obs, 7'b0100000);
        f_oc = 1'b0; f_sd = 1'b0; f_cv = 1'b0; f_ot = 1'b0;
        repeat (5) @(negedge clk);

        check(q.size() == 0, "R4 R7 R8 queued events seen", q.size(), 0);
        finish_run();
    end
endmodule